// File: doc/BRIEF.md
# Delayed Register Write Queue

This block holds register writes that must not land at once. A producer hands it a destination index, a 64-bit value, a delay and an optional bit selector. The entry then waits for a number of instruction ticks before it is presented on the commit port, where a register file (outside this block) applies it. A write can cover the whole destination, or it can change only one chosen bit of it.

The queue has a fixed ring of slots and an insert pointer that moves forward after each accepted write. Each slot keeps its own countdown. An accepted tick decrements every waiting slot. Slots that reach zero are handed out one per cycle, oldest insertion first. While any expired slot is still waiting to be handed out, the tick input is stalled. If the slot under the insert pointer is still busy, the new write is refused and an error is flagged. A flush input discards all pending work.

Top module: `delayed_write_queue`

## Requirements
- R1: After reset, pending_count is 0, commit_valid is 0, overflow_err is 0 and tick_ready is 1.
- R2: A write scheduled with delay d (0 to 15) expires on the (d+1)th accepted tick. commit_valid rises one clock after the edge that accepts that tick and stays high for one cycle per entry. Ticks before that point produce no commit.
- R3: Scheduling while the slot at the insert pointer is occupied sets overflow_err high for exactly the cycle after that edge. The write is dropped and the insert pointer does not move. This happens even when other slots are free.
- R4: With sched_bit_en = 0, commit_mask is all ones. With sched_bit_en = 1, commit_mask has only bit sched_bit set. commit_dest and commit_value equal the scheduled values.
- R5: flush empties every slot, resets the insert pointer to slot 0, clears pending_count and commit_valid at the next edge, and drops any schedule or tick presented in the same cycle. Entries discarded by a flush never commit.
- R6: When several slots expire on one tick, they commit on consecutive cycles in insertion order, including when the ring has wrapped. tick_ready is 0 from the expiring tick until the last of them has been handed out.
- R7: The insert pointer advances by one slot, modulo 8, after each accepted write. Eight writes into an empty queue are all accepted, and a ninth one overflows.
- R8: pending_count equals the number of occupied slots, from 0 to 8. It rises on each accepted write and falls on the edge that hands out a commit.
- R9: A write accepted in the same cycle as a tick is not decremented by that tick.
- R10: tick_valid has no effect while tick_ready is 0. Waiting entries keep their countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sched_valid | input | 1 | Request to schedule a write |
| sched_dest | input | REG_W | Destination register index |
| sched_value | input | DATA_W | Value to write |
| sched_delay | input | DLY_W | Extra ticks to wait (countdown is this plus one) |
| sched_bit_en | input | 1 | 1: write only one bit; 0: write whole destination |
| sched_bit | input | log2(DATA_W) | Bit position used when sched_bit_en is 1 |
| tick_valid | input | 1 | Instruction tick request |
| tick_ready | output | 1 | Tick can be accepted (no expired entry waiting) |
| flush | input | 1 | Discard all pending writes |
| commit_valid | output | 1 | A write is presented this cycle |
| commit_dest | output | REG_W | Destination of the presented write |
| commit_value | output | DATA_W | Value of the presented write |
| commit_mask | output | DATA_W | Bits of the destination to update |
| overflow_err | output | 1 | Pulse: last schedule hit an occupied slot |
| pending_count | output | log2(SLOTS+1) | Number of occupied slots |

## Verification
A stuck or wrong countdown shows up as a commit that comes one or more ticks early or late, or never comes. The sweep over every delay catches it within that write's own window. A corrupted occupancy bit or insert pointer first appears as a missed overflow pulse or a spurious one, or as pending_count drifting away from the number of writes in flight. Any of these is visible one edge after the schedule that exposes it. A wrong selection order is caught at the first multi-slot drain, because the commit_dest sequence comes out permuted.

// File: rtl/dwq_pkg.sv
package dwq_pkg;
  localparam int DWQ_SLOTS  = 8;
  localparam int DWQ_DATA_W = 64;
  localparam int DWQ_REG_W  = 6;
  localparam int DWQ_DLY_W  = 4;

  typedef enum logic {
    WMODE_WHOLE = 1'b0,
    WMODE_BIT   = 1'b1
  } wmode_e;
endpackage

// File: rtl/dwq_alloc.sv
module dwq_alloc #(
  parameter int SLOTS = 8,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             sched_valid,
  input  logic [SLOTS-1:0] occ,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             accept,
  output logic             overflow_err
);
  logic slot_busy;

  assign slot_busy = occ[wr_ptr];
  assign accept    = sched_valid && !flush && !slot_busy;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
    end else if (accept) begin
      if (wr_ptr == PTR_W'(SLOTS - 1)) wr_ptr <= '0;
      else                             wr_ptr <= wr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) overflow_err <= 1'b0;
    else     overflow_err <= sched_valid && !flush && slot_busy;
  end
endmodule

// File: rtl/dwq_slots.sv
module dwq_slots
  import dwq_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int DATA_W = 64,
  parameter int REG_W  = 6,
  parameter int DLY_W  = 4,
  parameter int BIT_W  = 6,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              accept,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [REG_W-1:0]  in_dest,
  input  logic [DATA_W-1:0] in_value,
  input  logic [DLY_W-1:0]  in_delay,
  input  wmode_e            in_mode,
  input  logic [BIT_W-1:0]  in_bit,
  input  logic              tick_go,
  input  logic              free_vld,
  input  logic [PTR_W-1:0]  free_idx,
  output logic [SLOTS-1:0]  occ,
  output logic [SLOTS-1:0]  expired,
  output logic [REG_W-1:0]  rd_dest,
  output logic [DATA_W-1:0] rd_value,
  output wmode_e            rd_mode,
  output logic [BIT_W-1:0]  rd_bit
);
  localparam int CD_W = DLY_W + 1;

  logic [REG_W-1:0]  mem_dest  [SLOTS];
  logic [DATA_W-1:0] mem_value [SLOTS];
  wmode_e            mem_mode  [SLOTS];
  logic [BIT_W-1:0]  mem_bit   [SLOTS];
  logic [CD_W-1:0]   init_cd;

  assign init_cd = {1'b0, in_delay} + CD_W'(1);

  always_ff @(posedge clk) begin
    if (accept) begin
      mem_dest[wr_ptr]  <= in_dest;
      mem_value[wr_ptr] <= in_value;
      mem_mode[wr_ptr]  <= in_mode;
      mem_bit[wr_ptr]   <= in_bit;
    end
  end

  assign rd_dest  = mem_dest[free_idx];
  assign rd_value = mem_value[free_idx];
  assign rd_mode  = mem_mode[free_idx];
  assign rd_bit   = mem_bit[free_idx];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [CD_W-1:0] cd;

    always_ff @(posedge clk) begin
      if (rst || flush) begin
        occ[i] <= 1'b0;
        cd     <= '0;
      end else if (accept && wr_ptr == PTR_W'(i)) begin
        occ[i] <= 1'b1;
        cd     <= init_cd;
      end else if (free_vld && free_idx == PTR_W'(i)) begin
        occ[i] <= 1'b0;
      end else if (tick_go && occ[i] && cd != '0) begin
        cd <= cd - 1'b1;
      end
    end

    assign expired[i] = occ[i] && (cd == '0);
  end
endmodule

// File: rtl/dwq_pick.sv
module dwq_pick #(
  parameter int SLOTS = 8,
  parameter int PTR_W = 3
) (
  input  logic [SLOTS-1:0] expired,
  input  logic [PTR_W-1:0] base,
  output logic             found,
  output logic [PTR_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = SLOTS - 1; k >= 0; k--) begin
      int p;
      p = int'(base) + k;
      if (p >= SLOTS) p = p - SLOTS;
      if (expired[p]) begin
        found = 1'b1;
        idx   = PTR_W'(p);
      end
    end
  end
endmodule

// File: rtl/delayed_write_queue.sv
module delayed_write_queue
  import dwq_pkg::*;
#(
  parameter  int SLOTS  = DWQ_SLOTS,
  parameter  int DATA_W = DWQ_DATA_W,
  parameter  int REG_W  = DWQ_REG_W,
  parameter  int DLY_W  = DWQ_DLY_W,
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sched_valid,
  input  logic [REG_W-1:0]  sched_dest,
  input  logic [DATA_W-1:0] sched_value,
  input  logic [DLY_W-1:0]  sched_delay,
  input  logic              sched_bit_en,
  input  logic [BIT_W-1:0]  sched_bit,
  input  logic              tick_valid,
  output logic              tick_ready,
  input  logic              flush,
  output logic              commit_valid,
  output logic [REG_W-1:0]  commit_dest,
  output logic [DATA_W-1:0] commit_value,
  output logic [DATA_W-1:0] commit_mask,
  output logic              overflow_err,
  output logic [CNT_W-1:0]  pending_count
);
  localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [PTR_W-1:0]  wr_ptr;
  logic              accept;
  logic [SLOTS-1:0]  occ;
  logic [SLOTS-1:0]  expired;
  logic              found;
  logic [PTR_W-1:0]  pick_idx;
  logic              free_vld;
  logic              tick_go;
  logic [REG_W-1:0]  rd_dest;
  logic [DATA_W-1:0] rd_value;
  wmode_e            rd_mode;
  logic [BIT_W-1:0]  rd_bit;
  wmode_e            in_mode;

  assign in_mode    = sched_bit_en ? WMODE_BIT : WMODE_WHOLE;
  assign tick_ready = ~|expired;
  assign tick_go    = tick_valid && tick_ready && !flush;
  assign free_vld   = found && !flush;

  dwq_alloc #(.SLOTS(SLOTS), .PTR_W(PTR_W)) u_alloc (
    .clk          (clk),
    .rst          (rst),
    .flush        (flush),
    .sched_valid  (sched_valid),
    .occ          (occ),
    .wr_ptr       (wr_ptr),
    .accept       (accept),
    .overflow_err (overflow_err)
  );

  dwq_slots #(
    .SLOTS(SLOTS), .DATA_W(DATA_W), .REG_W(REG_W),
    .DLY_W(DLY_W), .BIT_W(BIT_W), .PTR_W(PTR_W)
  ) u_slots (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .accept   (accept),
    .wr_ptr   (wr_ptr),
    .in_dest  (sched_dest),
    .in_value (sched_value),
    .in_delay (sched_delay),
    .in_mode  (in_mode),
    .in_bit   (sched_bit),
    .tick_go  (tick_go),
    .free_vld (free_vld),
    .free_idx (pick_idx),
    .occ      (occ),
    .expired  (expired),
    .rd_dest  (rd_dest),
    .rd_value (rd_value),
    .rd_mode  (rd_mode),
    .rd_bit   (rd_bit)
  );

  // Oldest insertion sits at the insert pointer, newer ones follow it.
  dwq_pick #(.SLOTS(SLOTS), .PTR_W(PTR_W)) u_pick (
    .expired (expired),
    .base    (wr_ptr),
    .found   (found),
    .idx     (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) commit_valid <= 1'b0;
    else              commit_valid <= free_vld;
  end

  always_ff @(posedge clk) begin
    if (free_vld) begin
      commit_dest  <= rd_dest;
      commit_value <= rd_value;
      if (rd_mode == WMODE_BIT) commit_mask <= {{(DATA_W-1){1'b0}}, 1'b1} << rd_bit;
      else                      commit_mask <= '1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush)
      pending_count <= '0;
    else
      pending_count <= pending_count + CNT_W'(accept) - CNT_W'(free_vld);
  end
endmodule

// File: rtl/dwq_checker.sv
module dwq_checker #(
  parameter int SLOTS = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sched_valid,
  input logic             flush,
  input logic             commit_valid,
  input logic             overflow_err,
  input logic [CNT_W-1:0] pending_count
);
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
    int'(pending_count) <= SLOTS);

  assert_commit_needs_pending_R2: assert property (@(posedge clk) disable iff (rst)
    commit_valid |-> $past(pending_count) != '0);

  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (rst)
    flush |=> (pending_count == '0) && !commit_valid);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (sched_valid && !flush && int'(pending_count) == SLOTS) |=> overflow_err);

  assert_overflow_cause_R3: assert property (@(posedge clk) disable iff (rst)
    overflow_err |-> $past(sched_valid) && !$past(flush));
endmodule

bind delayed_write_queue dwq_checker #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_dwq_chk (
  .clk           (clk),
  .rst           (rst),
  .sched_valid   (sched_valid),
  .flush         (flush),
  .commit_valid  (commit_valid),
  .overflow_err  (overflow_err),
  .pending_count (pending_count)
);

// File: tb/delayed_write_queue_test.sv
module delayed_write_queue_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sched_valid = 1'b0;
  logic [5:0]  sched_dest = '0;
  logic [63:0] sched_value = '0;
  logic [3:0]  sched_delay = '0;
  logic        sched_bit_en = 1'b0;
  logic [5:0]  sched_bit = '0;
  logic        tick_valid = 1'b0;
  logic        tick_ready;
  logic        flush = 1'b0;
  logic        commit_valid;
  logic [5:0]  commit_dest;
  logic [63:0] commit_value;
  logic [63:0] commit_mask;
  logic        overflow_err;
  logic [3:0]  pending_count;

  int vectors = 0;
  int fails   = 0;

  always #5 clk = ~clk;

  delayed_write_queue uut (
    .clk(clk), .rst(rst),
    .sched_valid(sched_valid), .sched_dest(sched_dest), .sched_value(sched_value),
    .sched_delay(sched_delay), .sched_bit_en(sched_bit_en), .sched_bit(sched_bit),
    .tick_valid(tick_valid), .tick_ready(tick_ready), .flush(flush),
    .commit_valid(commit_valid), .commit_dest(commit_dest),
    .commit_value(commit_value), .commit_mask(commit_mask),
    .overflow_err(overflow_err), .pending_count(pending_count)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_sched(input int dest, input logic [63:0] val, input int dly,
                           input bit ben, input int b);
    sched_valid  = 1'b1;
    sched_dest   = 6'(dest);
    sched_value  = val;
    sched_delay  = 4'(dly);
    sched_bit_en = ben;
    sched_bit    = 6'(b);
  endtask

  task automatic sched(input int dest, input logic [63:0] val, input int dly,
                       input bit ben, input int b);
    set_sched(dest, val, dly, ben, b);
    cyc();
    sched_valid = 1'b0;
  endtask

  task automatic tick();
    tick_valid = 1'b1;
    cyc();
    tick_valid = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    cyc();
    flush = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    // R1 reset state
    chk("R1 pending", 64'(pending_count), 0);
    chk("R1 commit_valid", 64'(commit_valid), 0);
    chk("R1 overflow", 64'(overflow_err), 0);
    chk("R1 tick_ready", 64'(tick_ready), 1);

    // R2 / R4 / R8: sweep every delay, whole-word mode
    for (int d = 0; d < 16; d++) begin
      logic [63:0] v;
      v = 64'h0123_4567_89AB_CDEF ^ (64'(d) * 64'h1111_1111_1111_1111);
      do_flush();
      sched(d + 3, v, d, 1'b0, 0);
      chk("R8 count after schedule", 64'(pending_count), 1);
      for (int t = 0; t < d; t++) begin
        tick();
        chk("R2 early commit", 64'(commit_valid), 0);
      end
      tick();
      chk("R6 stall on expiry", 64'(tick_ready), 0);
      chk("R2 not yet visible", 64'(commit_valid), 0);
      cyc();
      chk("R2 commit appears", 64'(commit_valid), 1);
      chk("R4 dest", 64'(commit_dest), 64'(d + 3));
      chk("R4 value", commit_value, v);
      chk("R4 whole mask", commit_mask, 64'hFFFF_FFFF_FFFF_FFFF);
      chk("R8 count after commit", 64'(pending_count), 0);
      cyc();
      chk("R2 single commit", 64'(commit_valid), 0);
    end

    // R4: every bit position, delay 0, ring wraps repeatedly (R7)
    do_flush();
    for (int b = 0; b < 64; b++) begin
      sched(b, ~64'(b), 0, 1'b1, b);
      tick();
      cyc();
      chk("R4 bit commit", 64'(commit_valid), 1);
      chk("R4 bit mask", commit_mask, 64'h1 << b);
      chk("R4 bit value", commit_value, ~64'(b));
    end

    // R7 / R3: fill eight, ninth overflows
    do_flush();
    for (int k = 0; k < 8; k++) begin
      sched(k, 64'(k), 15, 1'b0, 0);
      chk("R7 accepted", 64'(overflow_err), 0);
      chk("R8 fill count", 64'(pending_count), 64'(k + 1));
    end
    sched(40, 64'hDEAD, 0, 1'b0, 0);
    chk("R3 overflow pulse", 64'(overflow_err), 1);
    chk("R3 count unchanged", 64'(pending_count), 8);
    cyc();
    chk("R3 pulse one cycle", 64'(overflow_err), 0);

    // R5: flush discards, nothing commits later
    do_flush();
    chk("R5 count cleared", 64'(pending_count), 0);
    for (int t = 0; t < 20; t++) begin
      tick();
      chk("R5 no stale commit", 64'(commit_valid), 0);
    end

    // R3 with free slots: slot 0 long, slots 1..7 short; R6 drain order
    do_flush();
    sched(50, 64'h50, 15, 1'b0, 0);
    for (int k = 1; k < 8; k++) sched(50 + k, 64'(50 + k), 0, 1'b0, 0);
    tick();
    chk("R6 stalled", 64'(tick_ready), 0);
    for (int j = 1; j < 8; j++) begin
      cyc();
      chk("R6 drain valid", 64'(commit_valid), 1);
      chk("R6 drain order", 64'(commit_dest), 64'(50 + j));
    end
    chk("R6 ready after drain", 64'(tick_ready), 1);
    chk("R8 one left", 64'(pending_count), 1);
    sched(60, 64'h60, 0, 1'b0, 0);
    chk("R3 overflow with free slots", 64'(overflow_err), 1);
    chk("R3 dropped", 64'(pending_count), 1);

    // R6 wrap order and R10 ignored ticks
    do_flush();
    for (int k = 0; k < 6; k++) begin
      sched(k, 64'(k), 0, 1'b0, 0);
      tick();
      cyc();
    end
    sched(20, 64'h20, 1, 1'b0, 0);
    tick();
    sched(21, 64'h21, 0, 1'b0, 0);
    sched(22, 64'h22, 0, 1'b0, 0);
    tick();
    chk("R6 stall three expired", 64'(tick_ready), 0);
    tick_valid = 1'b1;
    set_sched(23, 64'h23, 0, 1'b0, 0);
    cyc();
    sched_valid = 1'b0;
    chk("R6 first oldest", 64'(commit_dest), 20);
    cyc();
    chk("R6 second", 64'(commit_dest), 21);
    cyc();
    tick_valid = 1'b0;
    chk("R6 third wrapped", 64'(commit_dest), 22);
    chk("R6 ready again", 64'(tick_ready), 1);
    chk("R10 survivor count", 64'(pending_count), 1);
    cyc();
    chk("R10 ticks ignored while stalled", 64'(commit_valid), 0);
    tick();
    cyc();
    chk("R10 survivor commits", 64'(commit_valid), 1);
    chk("R10 survivor dest", 64'(commit_dest), 23);

    // R9: schedule together with a tick
    do_flush();
    tick_valid = 1'b1;
    set_sched(30, 64'h30, 0, 1'b0, 0);
    cyc();
    tick_valid = 1'b0;
    sched_valid = 1'b0;
    cyc();
    chk("R9 not decremented", 64'(commit_valid), 0);
    chk("R9 still pending", 64'(pending_count), 1);
    tick();
    cyc();
    chk("R9 commits after own tick", 64'(commit_valid), 1);

    // R5: schedule in flush cycle is dropped
    flush = 1'b1;
    set_sched(31, 64'h31, 0, 1'b0, 0);
    cyc();
    flush = 1'b0;
    sched_valid = 1'b0;
    chk("R5 sched dropped", 64'(pending_count), 0);
    chk("R5 no overflow", 64'(overflow_err), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule